// File: doc/BRIEF.md
# Relative Branch Resolver

This unit settles a relative branch for an 8-bit-opcode processor core. The core presents four things on one clock edge with a valid strobe: the opcode, the address of the instruction that follows the branch, the branch displacement, and the current N, V, Z and C flags together with the emulation bit.

One cycle later the unit reports four results. It says whether the opcode is a branch at all and whether that branch is taken. It gives the address where execution continues and the number of machine cycles the branch costs. Fetching the displacement bytes, bank registers and pipeline flushing belong to the surrounding core. The unit has no flag outputs, so a branch cannot alter the status flags.

Results are registered. A result is loaded only in a cycle with the valid strobe, so it is held between requests.

Top module: `br_resolve`

## Requirements
- R1: The eight conditional short branches decode as follows, and each is taken exactly when its condition holds:
  - 0x90: taken when C=0.
  - 0xB0: taken when C=1.
  - 0xF0: taken when Z=1.
  - 0xD0: taken when Z=0.
  - 0x30: taken when N=1.
  - 0x10: taken when N=0.
  - 0x50: taken when V=0.
  - 0x70: taken when V=1.
- R2: Opcode 0x80 is a short branch that is taken for every flag combination.
- R3: Opcode 0x82 is always taken and uses all 16 bits of `offset`. It always costs 3 cycles, with no page penalty even when `emu`=1.
- R4: For short branches only `offset[7:0]` is used, sign-extended. The upper offset bits have no effect. The target is `next_pc` plus the extended offset, modulo 2^16.
- R5: A short branch that is not taken costs 2 cycles, and `dest` equals `next_pc`.
- R6: A taken short branch with `emu`=0 costs 3 cycles, whether or not a page is crossed. `dest` is the target.
- R7: A taken short branch with `emu`=1 costs 4 cycles when `dest[15:8]` differs from `next_pc[15:8]`, and 3 cycles otherwise. This holds in both the forward and the backward direction.
- R8: Any other opcode raises `not_branch`, with `taken`=0, `cycles`=0 and `dest`=`next_pc`.
- R9: Results appear with `out_valid`=1 on the clock edge after `in_valid`=1. With `in_valid`=0, `out_valid` is 0 and the other outputs keep their values.
- R10: Reset drives every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| opcode | input | 8 | Instruction opcode |
| next_pc | input | 16 | Address following the branch instruction |
| offset | input | 16 | Displacement (short branches use bits 7:0) |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| emu | input | 1 | Emulation mode bit |
| out_valid | output | 1 | Result strobe |
| taken | output | 1 | Branch taken |
| not_branch | output | 1 | Opcode is not a relative branch |
| dest | output | 16 | Continuation address |
| cycles | output | 3 | Cycle cost of the instruction |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, an 8-bit short displacement and a 256-byte page. These settings make three cases reachable: wrapping past 0xFFFF and below 0x0000, crossing a page in both directions, and a long displacement that spans the whole bank.

Every one of the 256 opcodes is run against all sixteen flag combinations in both modes. This confirms the decode and the not-a-branch path exhaustively. Directed cases then place targets just on either side of page boundaries, and hold the strobe low to show that results are retained.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_SHORT = 2'd1,
    BK_LONG  = 2'd2
  } br_kind_e;

  typedef enum logic [3:0] {
    CND_CC, CND_CS, CND_EQ, CND_NE,
    CND_MI, CND_PL, CND_VC, CND_VS,
    CND_AL
  } br_cond_e;

  typedef struct packed {
    logic n;
    logic v;
    logic z;
    logic c;
  } br_flags_t;

  localparam int unsigned CYC_NOT_TAKEN = 2;
  localparam int unsigned CYC_TAKEN     = 3;
  localparam int unsigned CYC_LONG      = 3;
endpackage

// File: rtl/br_decode.sv
module br_decode
  import br_pkg::*;
(
  input  logic [7:0] opcode,
  output br_kind_e   kind,
  output br_cond_e   cond
);
  always_comb begin
    kind = BK_SHORT;
    cond = CND_AL;
    unique case (opcode)
      8'h90: cond = CND_CC;
      8'hB0: cond = CND_CS;
      8'hF0: cond = CND_EQ;
      8'hD0: cond = CND_NE;
      8'h30: cond = CND_MI;
      8'h10: cond = CND_PL;
      8'h50: cond = CND_VC;
      8'h70: cond = CND_VS;
      8'h80: cond = CND_AL;
      8'h82: kind = BK_LONG;
      default: kind = BK_NONE;
    endcase
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
(
  input  br_cond_e  cond,
  input  br_flags_t flags,
  output logic      met
);
  always_comb begin
    unique case (cond)
      CND_CC:  met = ~flags.c;
      CND_CS:  met =  flags.c;
      CND_EQ:  met =  flags.z;
      CND_NE:  met = ~flags.z;
      CND_MI:  met =  flags.n;
      CND_PL:  met = ~flags.n;
      CND_VC:  met = ~flags.v;
      CND_VS:  met =  flags.v;
      default: met = 1'b1;
    endcase
  end
endmodule

// File: rtl/br_target.sv
module br_target #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned PAGE_W  = 8
) (
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [ADDR_W-1:0] offset,
  input  logic              use_full,
  output logic [ADDR_W-1:0] target,
  output logic              page_cross
);
  localparam int unsigned EXT_W = ADDR_W - SHORT_W;

  logic [ADDR_W-1:0] short_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign short_ext = {{EXT_W{offset[SHORT_W-1]}}, offset[SHORT_W-1:0]};
    end else begin : g_noext
      assign short_ext = offset;
    end
  endgenerate

  always_comb begin
    target     = next_pc + (use_full ? offset : short_ext);
    page_cross = (target[ADDR_W-1:PAGE_W] != next_pc[ADDR_W-1:PAGE_W]);
  end
endmodule

// File: rtl/br_resolve.sv
module br_resolve
  import br_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned SHORT_W = 8,
  parameter int unsigned PAGE_W  = 8,
  parameter int unsigned CYC_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [ADDR_W-1:0] offset,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              emu,
  output logic              out_valid,
  output logic              taken,
  output logic              not_branch,
  output logic [ADDR_W-1:0] dest,
  output logic [CYC_W-1:0]  cycles
);
  br_kind_e          kind;
  br_cond_e          cond;
  logic              cond_met;
  logic [ADDR_W-1:0] tgt;
  logic              crossed;
  br_flags_t         flags;

  assign flags = '{n: flag_n, v: flag_v, z: flag_z, c: flag_c};

  br_decode u_dec (
    .opcode (opcode),
    .kind   (kind),
    .cond   (cond)
  );

  br_cond_eval u_cnd (
    .cond  (cond),
    .flags (flags),
    .met   (cond_met)
  );

  br_target #(
    .ADDR_W  (ADDR_W),
    .SHORT_W (SHORT_W),
    .PAGE_W  (PAGE_W)
  ) u_tgt (
    .next_pc    (next_pc),
    .offset     (offset),
    .use_full   (kind == BK_LONG),
    .target     (tgt),
    .page_cross (crossed)
  );

  logic              taken_d;
  logic              nb_d;
  logic [ADDR_W-1:0] dest_d;
  logic [CYC_W-1:0]  cyc_d;

  always_comb begin
    taken_d = 1'b0;
    nb_d    = 1'b0;
    dest_d  = next_pc;
    cyc_d   = '0;
    unique case (kind)
      BK_LONG: begin
        taken_d = 1'b1;
        dest_d  = tgt;
        cyc_d   = CYC_W'(CYC_LONG);
      end
      BK_SHORT: begin
        taken_d = cond_met;
        if (cond_met) begin
          dest_d = tgt;
          cyc_d  = CYC_W'(CYC_TAKEN) + CYC_W'(emu && crossed);
        end else begin
          cyc_d  = CYC_W'(CYC_NOT_TAKEN);
        end
      end
      default: nb_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      taken      <= 1'b0;
      not_branch <= 1'b0;
      dest       <= '0;
      cycles     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken      <= taken_d;
        not_branch <= nb_d;
        dest       <= dest_d;
        cycles     <= cyc_d;
      end
    end
  end

  AST_LONG_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && opcode == 8'h82 |=> taken && cycles == CYC_W'(3)); // R3
  AST_NATIVE_NO_PENALTY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !emu |=> cycles != CYC_W'(4)); // R6
  AST_NOT_TAKEN_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> taken || dest == $past(next_pc)); // R5
  AST_NB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && not_branch |-> !taken && cycles == '0); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(dest) && $stable(cycles)); // R9
endmodule

// File: tb/tb_br_resolve.sv
module tb_br_resolve;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  opcode;
  logic [15:0] next_pc;
  logic [15:0] offset;
  logic        flag_n, flag_v, flag_z, flag_c, emu;
  logic        out_valid, taken, not_branch;
  logic [15:0] dest;
  logic [2:0]  cycles;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic        tk;
    logic        nb;
    logic [15:0] dst;
    logic [2:0]  cyc;
    string       tag;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  br_resolve dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .next_pc(next_pc), .offset(offset), .flag_n(flag_n), .flag_v(flag_v),
    .flag_z(flag_z), .flag_c(flag_c), .emu(emu), .out_valid(out_valid),
    .taken(taken), .not_branch(not_branch), .dest(dest), .cycles(cycles)
  );

  function automatic exp_t model(input logic [7:0] op, input logic [15:0] pc,
                                 input logic [15:0] off, input logic [3:0] f,
                                 input logic e);
    exp_t r;
    logic n, v, z, c, isb, cnd;
    logic [15:0] t;
    {n, v, z, c} = f;
    isb = 1'b1;
    cnd = 1'b0;
    case (op)
      8'h90: cnd = !c;
      8'hB0: cnd = c;
      8'hF0: cnd = z;
      8'hD0: cnd = !z;
      8'h30: cnd = n;
      8'h10: cnd = !n;
      8'h50: cnd = !v;
      8'h70: cnd = v;
      8'h80: cnd = 1'b1;
      8'h82: cnd = 1'b1;
      default: isb = 1'b0;
    endcase
    r.nb = !isb;
    r.tk = isb && cnd;
    if (!isb) begin
      r.dst = pc; r.cyc = 3'd0; r.tag = "R8";
    end else if (op == 8'h82) begin
      r.dst = pc + off; r.cyc = 3'd3; r.tag = "R3";
    end else if (!cnd) begin
      r.dst = pc; r.cyc = 3'd2; r.tag = "R5/R1";
    end else begin
      t = pc + {{8{off[7]}}, off[7:0]};
      r.dst = t;
      if (e && t[15:8] != pc[15:8]) begin
        r.cyc = 3'd4; r.tag = "R7/R4";
      end else begin
        r.cyc = 3'd3; r.tag = (op == 8'h80) ? "R2/R6" : "R6/R1";
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [7:0] op, input logic [15:0] pc,
                       input logic [15:0] off, input logic [3:0] f, input logic e);
    @(negedge clk);
    in_valid = 1'b1;
    opcode = op; next_pc = pc; offset = off;
    {flag_n, flag_v, flag_z, flag_c} = f;
    emu = e;
    sb.push_back(model(op, pc, off, f, e));
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
    opcode = 8'hA9; next_pc = 16'h5555; offset = 16'h00AA;
  endtask

  // Monitor: compare results against the scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && out_valid) begin
        exp_t e;
        checks++;
        if (sb.size() == 0) begin
          failures++;
          $display("FAIL R9 unexpected result: actual=out_valid expected=no result");
        end else begin
          e = sb.pop_front();
          if (taken !== e.tk || not_branch !== e.nb || dest !== e.dst || cycles !== e.cyc) begin
            failures++;
            $display("FAIL %s op=%h: actual tk=%b nb=%b dest=%h cyc=%0d expected tk=%b nb=%b dest=%h cyc=%0d",
                     e.tag, opcode, taken, not_branch, dest, cycles, e.tk, e.nb, e.dst, e.cyc);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; in_valid = 1'b0; opcode = '0; next_pc = '0; offset = '0;
    flag_n = 0; flag_v = 0; flag_z = 0; flag_c = 0; emu = 0;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if (out_valid !== 0 || taken !== 0 || not_branch !== 0 || dest !== 0 || cycles !== 0) begin
      failures++;
      $display("FAIL R10 reset: actual v=%b tk=%b nb=%b dest=%h cyc=%0d expected all 0",
               out_valid, taken, not_branch, dest, cycles);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // Exhaustive opcode x flags x mode sweep (R1, R2, R3, R5, R6, R8)
    for (int op = 0; op < 256; op++) begin
      for (int f = 0; f < 16; f++) begin
        for (int e = 0; e < 2; e++) begin
          drive(8'(op), 16'h1234 + 16'(op), 16'h8F10 + 16'(f), 4'(f), e[0]);
        end
      end
    end

    // Page crossing forward and backward, both modes (R7, R6, R4)
    for (int e = 0; e < 2; e++) begin
      drive(8'h80, 16'h10F0, 16'h0010, 4'h0, e[0]); // forward to 0x1100
      drive(8'h80, 16'h10F0, 16'h000F, 4'h0, e[0]); // stays at 0x10FF
      drive(8'h80, 16'h1005, 16'h00FA, 4'h0, e[0]); // -6 back to 0x0FFF
      drive(8'h80, 16'h1005, 16'h00FB, 4'h0, e[0]); // -5 stays at 0x1000
      drive(8'hF0, 16'h2080, 16'hFF80, 4'h2, e[0]); // -128 stays in page
      drive(8'hF0, 16'h2000, 16'h0080, 4'h2, e[0]); // -128 into previous page
      drive(8'hB0, 16'hFFF0, 16'h0020, 4'h1, e[0]); // wraps to 0x0010
      drive(8'h90, 16'h0004, 16'h00F0, 4'h0, e[0]); // wraps to 0xFFF4
      drive(8'h82, 16'h10F0, 16'h7F00, 4'h0, e[0]); // long, no penalty
      drive(8'h82, 16'hF000, 16'h2000, 4'hF, e[0]); // long wraps
    end

    // Hold with strobe low (R9)
    drive(8'h80, 16'h3000, 16'h0042, 4'h0, 1'b1);
    idle();
    held = 16'h3042;
    @(posedge clk);
    #2;
    checks++;
    if (out_valid !== 1'b0 || dest !== held || cycles !== 3'd3) begin
      failures++;
      $display("FAIL R9 hold: actual v=%b dest=%h cyc=%0d expected v=0 dest=%h cyc=3",
               out_valid, dest, cycles, held);
    end
    repeat (3) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL R9 results missing: actual=%0d pending expected=0", sb.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule